// File: doc/BRIEF.md
# Next-Free Entry Tracker with Full-Flag Cascade

This block sits beside a small associative memory. Each entry of that memory carries an empty bit, and the block receives all of them as one vector. On every clock it finds the lowest-numbered empty entry and registers that index as the next free address. Later writes aimed at "the next free slot" use this address as their pointer. The block also registers an active-low full flag, which drops when no entry is empty.

Several devices can be cascaded through an active-low full-flag chain. The first device has its chain input tied LOW. Each device passes the chain on to the next device. The chain output goes LOW only when the chain input is LOW and the device itself is full. The single device whose chain input is LOW and which still has space owns next-free operations.

A next-free read is steered in one of two ways. With the cascade enable LOW, only the owning device answers. With the cascade enable HIGH, the device whose page address equals the device-select value answers, and the chain state plays no part.

Top module: `nxt_free_chain`

## Requirements
- R1: While reset is asserted, `nf_addr` is zero and `full_n` is HIGH.
- R2: One clock after `empty_vec` is presented, `nf_addr` holds the index of the lowest set bit of `empty_vec`, where bit i stands for entry i.
- R3: One clock after `empty_vec` is presented, `full_n` is LOW if `empty_vec` has no set bit, and HIGH otherwise.
- R4: While `full_n` is LOW, `nf_addr` is all ones.
- R5: `chain_out_n` is LOW exactly when `chain_in_n` is LOW and `full_n` is LOW. In every other case it is HIGH.
- R6: `owner` is HIGH exactly when `chain_in_n` is LOW and `full_n` is HIGH. In a chain whose first device has its input tied LOW, at most one device is owner.
- R7: With `cascade_en_n` LOW, `rd_resp_en` equals `nf_rd` AND `owner`.
- R8: With `cascade_en_n` HIGH, `rd_resp_en` equals `nf_rd` AND (`dev_sel` == `page_addr`). The chain state has no effect on it.
- R9: `rd_resp_en` is LOW whenever `nf_rd` is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| empty_vec | input | N_ENTRIES | Per-entry empty bits, bit i = entry i |
| chain_in_n | input | 1 | Full-flag chain input, LOW = all upstream devices full |
| cascade_en_n | input | 1 | LOW = chain selects the responder, HIGH = page match selects it |
| nf_rd | input | 1 | Next-free read strobe |
| dev_sel | input | PAGE_W | Device-select value |
| page_addr | input | PAGE_W | This device's page address |
| nf_addr | output | ADDR_W | Registered next free address |
| full_n | output | 1 | Registered internal full flag, LOW = full |
| chain_out_n | output | 1 | Full-flag chain output to the next device |
| owner | output | 1 | This device owns next-free operations |
| rd_resp_en | output | 1 | This device drives the next-free read response |

## Verification
On every cycle, the assertions check these relations:
- the registered address points at an entry that was empty on the previous cycle;
- the full flag and the all-ones address agree;
- the chain output stays HIGH while the chain input is HIGH;
- ownership and read response imply their enabling conditions.

Only the bench's scenarios can show the rest:
- that the address is the lowest empty entry rather than just some empty entry;
- that ownership moves to the downstream device as the upstream one fills;
- that page-select reads ignore the chain.

The bench shows these with two cascaded instances swept over every fill pattern of the first device.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  // Chain output: stays inactive unless upstream is full and this device is full.
  function automatic logic chain_pass_n(input logic in_n, input logic full_n_i);
    return in_n | full_n_i;
  endfunction

  // Ownership of next-free operations.
  function automatic logic owns_slot(input logic in_n, input logic full_n_i);
    return ~in_n & full_n_i;
  endfunction

  // Read steering: chain mode or page-select mode.
  function automatic logic resp_hit(input logic casc_n, input logic page_eq,
                                    input logic own_i);
    return casc_n ? page_eq : own_i;
  endfunction

endpackage

// File: rtl/nfc_first_empty.sv
module nfc_first_empty #(
  parameter int N_ENTRIES = 16,
  localparam int ADDR_W = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] empty_vec,
  output logic [ADDR_W-1:0]    first_idx,
  output logic                 any_empty
);

  logic [N_ENTRIES-1:0] below_any;
  logic [N_ENTRIES-1:0] first_hot;

  // below_any[i] is set when some entry under i is empty.
  assign below_any[0] = 1'b0;
  assign first_hot[0] = empty_vec[0];

  genvar gi;
  generate
    for (gi = 1; gi < N_ENTRIES; gi++) begin : g_scan
      assign below_any[gi] = below_any[gi-1] | empty_vec[gi-1];
      assign first_hot[gi] = empty_vec[gi] & ~below_any[gi];
    end
  endgenerate

  always_comb begin
    first_idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (first_hot[i]) first_idx = first_idx | ADDR_W'(i);
    end
  end

  assign any_empty = |empty_vec;

endmodule

// File: rtl/nfc_ptr_reg.sv
module nfc_ptr_reg #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] first_idx,
  input  logic              any_empty,
  output logic [ADDR_W-1:0] nf_addr,
  output logic              full_n
);

  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nf_addr <= '0;
      full_n  <= 1'b1;
    end else begin
      nf_addr <= any_empty ? first_idx : ALL_ONES;
      full_n  <= any_empty;
    end
  end

endmodule

// File: rtl/nfc_chain_resp.sv
module nfc_chain_resp
  import nfc_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              full_n,
  input  logic              chain_in_n,
  input  logic              cascade_en_n,
  input  logic              nf_rd,
  input  logic [PAGE_W-1:0] dev_sel,
  input  logic [PAGE_W-1:0] page_addr,
  output logic              chain_out_n,
  output logic              owner,
  output logic              page_eq,
  output logic              rd_resp_en
);

  assign page_eq     = (dev_sel == page_addr);
  assign owner       = owns_slot(chain_in_n, full_n);
  assign chain_out_n = chain_pass_n(chain_in_n, full_n);
  assign rd_resp_en  = nf_rd & resp_hit(cascade_en_n, page_eq, owner);

endmodule

// File: rtl/nxt_free_chain.sv
module nxt_free_chain #(
  parameter int N_ENTRIES = 16,
  parameter int PAGE_W    = 4,
  localparam int ADDR_W   = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ENTRIES-1:0] empty_vec,
  input  logic                 chain_in_n,
  input  logic                 cascade_en_n,
  input  logic                 nf_rd,
  input  logic [PAGE_W-1:0]    dev_sel,
  input  logic [PAGE_W-1:0]    page_addr,
  output logic [ADDR_W-1:0]    nf_addr,
  output logic                 full_n,
  output logic                 chain_out_n,
  output logic                 owner,
  output logic                 rd_resp_en
);

  // Named internal events, also used by the checker.
  logic [ADDR_W-1:0] first_idx;
  logic              any_empty;
  logic              page_eq;

  nfc_first_empty #(.N_ENTRIES(N_ENTRIES)) u_enc (
    .empty_vec (empty_vec),
    .first_idx (first_idx),
    .any_empty (any_empty)
  );

  nfc_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_idx (first_idx),
    .any_empty (any_empty),
    .nf_addr   (nf_addr),
    .full_n    (full_n)
  );

  nfc_chain_resp #(.PAGE_W(PAGE_W)) u_chain (
    .full_n       (full_n),
    .chain_in_n   (chain_in_n),
    .cascade_en_n (cascade_en_n),
    .nf_rd        (nf_rd),
    .dev_sel      (dev_sel),
    .page_addr    (page_addr),
    .chain_out_n  (chain_out_n),
    .owner        (owner),
    .page_eq      (page_eq),
    .rd_resp_en   (rd_resp_en)
  );

endmodule

// File: rtl/nxt_free_chain_chk.sv
module nxt_free_chain_chk #(
  parameter int N_ENTRIES = 16,
  parameter int PAGE_W    = 4,
  localparam int ADDR_W   = $clog2(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_ENTRIES-1:0] empty_vec,
  input logic                 chain_in_n,
  input logic                 cascade_en_n,
  input logic                 nf_rd,
  input logic [PAGE_W-1:0]    dev_sel,
  input logic [PAGE_W-1:0]    page_addr,
  input logic [ADDR_W-1:0]    nf_addr,
  input logic                 full_n,
  input logic                 chain_out_n,
  input logic                 owner,
  input logic                 rd_resp_en,
  input logic                 any_empty
);

  logic was_run;
  always_ff @(posedge clk) was_run <= rst_n;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (!rst_n || was_run) || (nf_addr == '0 && full_n)); // R1
  AST_NF_WAS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (was_run && full_n) |-> ((($past(empty_vec) >> nf_addr) & 1) != 0)); // R2
  AST_FULL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    was_run |-> (full_n == $past(any_empty))); // R3
  AST_FULL_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (nf_addr == {ADDR_W{1'b1}})); // R4
  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chain_in_n |-> chain_out_n); // R5
  AST_OWNER_COND: assert property (@(posedge clk) disable iff (!rst_n)
    owner |-> (full_n && !chain_in_n)); // R6
  AST_CHAIN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp_en && !cascade_en_n) |-> owner); // R7
  AST_PAGE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp_en && cascade_en_n) |-> (dev_sel == page_addr)); // R8
  AST_NO_RD_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_rd |-> !rd_resp_en); // R9

endmodule

bind nxt_free_chain nxt_free_chain_chk #(.N_ENTRIES(N_ENTRIES), .PAGE_W(PAGE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .empty_vec    (empty_vec),
  .chain_in_n   (chain_in_n),
  .cascade_en_n (cascade_en_n),
  .nf_rd        (nf_rd),
  .dev_sel      (dev_sel),
  .page_addr    (page_addr),
  .nf_addr      (nf_addr),
  .full_n       (full_n),
  .chain_out_n  (chain_out_n),
  .owner        (owner),
  .rd_resp_en   (rd_resp_en),
  .any_empty    (any_empty)
);

// File: tb/test_nxt_free_chain.sv
module test_nxt_free_chain;

  localparam int N  = 8;
  localparam int PW = 2;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] emp0 = '0, emp1 = '0;
  logic chain0_n = 1'b0, casc_n = 1'b0, rd = 1'b0;
  logic [PW-1:0] sel = '0;
  logic [AW-1:0] nf0, nf1;
  logic f0, f1, co0, co1, own0, own1, rsp0, rsp1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nxt_free_chain #(.N_ENTRIES(N), .PAGE_W(PW)) i_nxt_free_chain (
    .clk(clk), .rst_n(rst_n), .empty_vec(emp0), .chain_in_n(chain0_n),
    .cascade_en_n(casc_n), .nf_rd(rd), .dev_sel(sel), .page_addr(2'd0),
    .nf_addr(nf0), .full_n(f0), .chain_out_n(co0), .owner(own0), .rd_resp_en(rsp0));

  nxt_free_chain #(.N_ENTRIES(N), .PAGE_W(PW)) i_nxt_free_chain_b (
    .clk(clk), .rst_n(rst_n), .empty_vec(emp1), .chain_in_n(co0),
    .cascade_en_n(casc_n), .nf_rd(rd), .dev_sel(sel), .page_addr(2'd1),
    .nf_addr(nf1), .full_n(f1), .chain_out_n(co1), .owner(own1), .rd_resp_en(rsp1));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (emp0=%h emp1=%h c0=%0b casc=%0b rd=%0b sel=%0d)",
               req, act, exp, emp0, emp1, chain0_n, casc_n, rd, sel);
    end
  endtask

  // Lowest set bit, found by scanning downwards; all ones if none.
  function automatic int low_empty(input logic [N-1:0] v);
    int r = (1 << AW) - 1;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  task automatic step_and_check(input logic [N-1:0] a, input logic [N-1:0] b,
                                input logic c0, input logic ce, input logic r,
                                input logic [PW-1:0] s);
    int ef0, ef1, eco0, eco1, eown0, eown1;
    emp0 = a; emp1 = b; chain0_n = c0; casc_n = ce; rd = r; sel = s;
    @(negedge clk);
    ef0 = (a != 0); ef1 = (b != 0);
    eco0 = (c0 || ef0) ? 1 : 0;
    eco1 = (eco0 || ef1) ? 1 : 0;
    eown0 = (!c0 && ef0) ? 1 : 0;
    eown1 = (eco0 == 0 && ef1) ? 1 : 0;
    check("R2 nf0", int'(nf0), low_empty(a));   // R4 covered when a==0
    check("R2 nf1", int'(nf1), low_empty(b));
    check("R3 full0", int'(f0), ef0);
    check("R3 full1", int'(f1), ef1);
    check("R5 chain0", int'(co0), eco0);
    check("R5 chain1", int'(co1), eco1);
    check("R6 own0", int'(own0), eown0);
    check("R6 own1", int'(own1), eown1);
    if (ce) begin
      check("R8 rsp0", int'(rsp0), (r && s == 0) ? 1 : 0);
      check("R8 rsp1", int'(rsp1), (r && s == 1) ? 1 : 0);
    end else begin
      check("R7 rsp0", int'(rsp0), r ? eown0 : 0);
      check("R7 rsp1", int'(rsp1), r ? eown1 : 0);
    end
    if (!r) check("R9 quiet", int'(rsp0 | rsp1), 0);
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    emp0 = 8'hFF; emp1 = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 nf0 reset", int'(nf0), 0);
    check("R1 full0 reset", int'(f0), 1);
    check("R1 nf1 reset", int'(nf1), 0);
    check("R1 full1 reset", int'(f1), 1);
    rst_n = 1'b1;
    // Exhaustive sweep of device 0 fill patterns, a few device 1 patterns.
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 4; k++) begin
          logic [N-1:0] b;
          case (k)
            0: b = '0;
            1: b = 8'h80;
            2: b = 8'h01;
            default: b = {a[0], a[1], a[2], a[3], a[4], a[5], a[6], a[7]};
          endcase
          step_and_check(a[N-1:0], b, c[0], a[1] ^ k[0], a[0] | k[1],
                         PW'(a[3:2] ^ k[1:0]));
        end
      end
    end
    // Ownership handover: fill device 0 one entry at a time.
    for (int n = 0; n <= N; n++) begin
      logic [N-1:0] a0 = ~((1 << n) - 1);
      step_and_check(a0[N-1:0], 8'h3C, 1'b0, 1'b0, 1'b1, 2'd3);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule